// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block produces the reset for a processor from two kinds of evidence. The first is a digitised supply-valid flag from an upstream comparator. The second is a watchdog line that software must keep toggling. Reset is held while the supply flag is false. After the supply recovers, reset is stretched by a fixed number of clock ticks. A watchdog timeout produces a reset pulse of that same width.

The watchdog line is a three-state code: driven low, driven high, or floating. A floating line switches the watchdog off. Both inputs first pass through two-flop synchronisers. The reset is presented on two outputs: an active-low output and its exact active-high inverse. The pulse width and the timeout are parameters given in clock ticks. Their defaults are scaled down so that simulation stays short.

Top module: `sup_reset_gen`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` reads 0 and `rst_out` reads 1. After `rst_n` rises, a full reset pulse follows.
- R2: Whenever the synchronised supply flag is false, reset is asserted at the next clock edge. Once the flag has been true for RST_TICKS cycles, reset is released.
- R3: A supply drop during an active pulse restarts the pulse count from zero. A full RST_TICKS interval then runs after the flag recovers.
- R4: The watchdog code is 2'b00 for driven low and 2'b01 for driven high. 2'b10 and 2'b11 both mean floating. If the synchronised code stays at one driven level for WD_TICKS cycles after release, reset asserts and stays asserted for exactly RST_TICKS cycles.
- R5: A change between the low and high codes clears the watchdog count, however short the excursion is. Toggling more often than every WD_TICKS cycles therefore keeps reset released.
- R6: A floating code holds the watchdog count at zero, so no timeout ever occurs. Entering or leaving the floating code is not counted as a transition.
- R7: The watchdog count stays at zero while reset is asserted. With a constant driven level, the output repeats a released run of WD_TICKS cycles and an asserted run of RST_TICKS cycles.
- R8: `rst_out` is always the logical inverse of `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| supply_ok | input | 1 | Supply-valid flag from the upstream comparator |
| wdog_code | input | 2 | Watchdog line state: 00 low, 01 high, 1x floating |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |

## Verification
The bench drops the supply in the middle of a pulse. A design that resumes its count instead of restarting would release reset early. It holds the watchdog at one level so it can measure the released and asserted run lengths. A counter that is not cleared during reset would shorten the released run below WD_TICKS.

The bench also parks the line at floating for several timeout periods. A design that keeps counting would fire a spurious pulse. Toggles shorter than the timeout must keep reset released. Random mixes of glitches and code changes are compared cycle by cycle against a reference model kept in the bench.

// File: rtl/sup_reset_pkg.sv
// Shared definitions for the supervisory reset generator.
// Assumes a 2-bit watchdog code in which bit 1 set means the line floats.
package sup_reset_pkg;
    typedef enum logic [1:0] {
        WD_LOW   = 2'b00,
        WD_HIGH  = 2'b01,
        WD_FLOAT = 2'b10
    } wd_code_e;

    // True when the code stands for a driven logic level.
    function automatic logic wd_driven(input logic [1:0] code);
        return ~code[1];
    endfunction
endpackage

// File: rtl/sup_sync2.sv
// Two-flop synchroniser for a vector of independent slow signals.
// Assumes each bit settles between flops; RST_VAL loads on reset.
module sup_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sup_wdog_timer.sv
// Watchdog counter: clears on a low/high change, while the line floats,
// or while reset is held. Flags expiry after WD_TICKS counting cycles.
// Assumes code_s is already synchronised.
module sup_wdog_timer
    import sup_reset_pkg::*;
#(
    parameter int WD_TICKS = 64,
    localparam int WCW     = $clog2(WD_TICKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     code_s,
    input  logic           hold,
    output logic           kick,
    output logic           floating,
    output logic           expire,
    output logic [WCW-1:0] wd_cnt
);
    logic [1:0] prev_code;
    logic       count_en;

    // A kick is a change between two driven levels; floating never counts.
    always_comb begin
        floating = ~wd_driven(code_s);
        kick     = wd_driven(code_s) && wd_driven(prev_code) &&
                   (code_s[0] != prev_code[0]);
        count_en = !hold && !floating && !kick;
        expire   = count_en && (wd_cnt == WCW'(WD_TICKS - 1));
    end

    // Remember the previous synchronised code for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_code <= WD_FLOAT;
        else        prev_code <= code_s;
    end

    // Count while enabled; saturate at the expiry value.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en)               wd_cnt <= '0;
        else if (wd_cnt != WCW'(WD_TICKS - 1)) wd_cnt <= wd_cnt + 1'b1;
    end
endmodule

// File: rtl/sup_pulse_gen.sv
// Reset pulse stretcher. Holds reset while the supply is bad or a
// trigger is present, then releases it RST_TICKS cycles later.
// Assumes sok_s is synchronised.
module sup_pulse_gen #(
    parameter int RST_TICKS = 16,
    localparam int RCW      = $clog2(RST_TICKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sok_s,
    input  logic           trigger,
    output logic           asserted,
    output logic [RCW-1:0] pcnt
);
    // Restart on any cause; count out the stretch once all causes clear.
    always_ff @(posedge clk) begin
        if (!rst_n || !sok_s || trigger) begin
            asserted <= 1'b1;
            pcnt     <= '0;
        end else if (asserted) begin
            if (pcnt == RCW'(RST_TICKS - 1)) asserted <= 1'b0;
            else                             pcnt     <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_reset_gen.sv
// Top of the supervisory reset generator. Synchronises the supply flag
// and the watchdog code, runs the watchdog, and stretches the reset.
// Assumes the tick parameters are at least 2.
module sup_reset_gen
    import sup_reset_pkg::*;
#(
    parameter int RST_TICKS = 2000,
    parameter int WD_TICKS  = 16000,
    localparam int RCW      = $clog2(RST_TICKS + 1),
    localparam int WCW      = $clog2(WD_TICKS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic [1:0] wdog_code,
    output logic       rst_out_n,
    output logic       rst_out
);
    logic           sok_s;
    logic [1:0]     code_s;
    logic           kick;
    logic           floating;
    logic           expire;
    logic [WCW-1:0] wd_cnt;
    logic           asserted;
    logic [RCW-1:0] pcnt;

    sup_sync2 #(.W(1), .RST_VAL(1'b0)) u_sync_sup (
        .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(sok_s)
    );

    sup_sync2 #(.W(2), .RST_VAL(WD_FLOAT)) u_sync_wd (
        .clk(clk), .rst_n(rst_n), .d(wdog_code), .q(code_s)
    );

    sup_wdog_timer #(.WD_TICKS(WD_TICKS)) u_wdog (
        .clk(clk), .rst_n(rst_n), .code_s(code_s), .hold(asserted),
        .kick(kick), .floating(floating), .expire(expire), .wd_cnt(wd_cnt)
    );

    sup_pulse_gen #(.RST_TICKS(RST_TICKS)) u_pulse (
        .clk(clk), .rst_n(rst_n), .sok_s(sok_s), .trigger(expire),
        .asserted(asserted), .pcnt(pcnt)
    );

    // Drive both polarities from the one pulse register.
    always_comb begin
        rst_out_n = ~asserted;
        rst_out   = asserted;
    end
endmodule

// File: rtl/sup_reset_gen_chk.sv
// Property checker for sup_reset_gen, attached with bind below.
module sup_reset_gen_chk #(
    parameter int RST_TICKS = 2000,
    parameter int WD_TICKS  = 16000,
    localparam int RCW      = $clog2(RST_TICKS + 1),
    localparam int WCW      = $clog2(WD_TICKS + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sok_s,
    input logic           kick,
    input logic           floating,
    input logic           expire,
    input logic [WCW-1:0] wd_cnt,
    input logic [RCW-1:0] pcnt,
    input logic           rst_out_n,
    input logic           rst_out
);
    a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == !rst_out_n);
    a_r2_low_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        !sok_s |=> !rst_out_n);
    a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !sok_s |=> pcnt == '0);
    a_r4_timeout_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (!rst_out_n && pcnt == '0));
    a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> wd_cnt == '0);
    a_r6_float_clears: assert property (@(posedge clk) disable iff (!rst_n)
        floating |=> wd_cnt == '0);
    a_r7_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_out_n |=> wd_cnt == '0);
endmodule

bind sup_reset_gen sup_reset_gen_chk #(
    .RST_TICKS(RST_TICKS), .WD_TICKS(WD_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sok_s(sok_s), .kick(kick),
    .floating(floating), .expire(expire), .wd_cnt(wd_cnt), .pcnt(pcnt),
    .rst_out_n(rst_out_n), .rst_out(rst_out)
);

// File: tb/sup_reset_gen_tb.sv
module sup_reset_gen_tb;
    localparam int RT = 20;
    localparam int WT = 50;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic [1:0] wdog_code = 2'b10;
    logic       rst_out_n, rst_out;

    int checks = 0, failures = 0, cyc = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    sup_reset_gen #(.RST_TICKS(RT), .WD_TICKS(WT)) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .wdog_code(wdog_code), .rst_out_n(rst_out_n), .rst_out(rst_out)
    );

    always #2 clk = ~clk;

    // Reference model built from the requirements.
    logic       m_s1, m_s2, m_asr;
    logic [1:0] m_c1, m_c2, m_prev;
    int         m_p, m_w;

    function automatic bit drv(input logic [1:0] c);
        return c[1] == 1'b0;
    endfunction

    always @(posedge clk) begin
        bit kk, en, ex;
        kk = drv(m_c2) && drv(m_prev) && (m_c2[0] != m_prev[0]);
        en = !m_asr && drv(m_c2) && !kk;
        ex = en && (m_w == WT - 1);
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_c1 <= 2'b10; m_c2 <= 2'b10;
            m_prev <= 2'b10; m_asr <= 1; m_p <= 0; m_w <= 0;
        end else begin
            m_s1 <= supply_ok; m_s2 <= m_s1;
            m_c1 <= wdog_code; m_c2 <= m_c1; m_prev <= m_c2;
            if (!en) m_w <= 0; else if (m_w != WT - 1) m_w <= m_w + 1;
            if (!m_s2 || ex) begin m_asr <= 1; m_p <= 0; end
            else if (m_asr) begin
                if (m_p == RT - 1) m_asr <= 0; else m_p <= m_p + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Cycle-by-cycle comparison and run-length tracking.
    int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, rst_out_n, !m_asr);
            check("R8", rst_out, !rst_out_n);
            if (rst_out_n) begin
                if (lo_run != 0) last_lo = lo_run;
                lo_run = 0; hi_run++;
            end else begin
                if (hi_run != 0) last_hi = hi_run;
                hi_run = 0; lo_run++;
            end
        end
    end

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_n(3);
        check("R1", rst_out_n, 0);                       // R1 during reset
        check("R1", rst_out, 1);
        supply_ok = 1; wdog_code = 2'b10;
        @(negedge clk) rst_n = 1;
        cur_req = "R1";
        wait_n(RT + 5);
        check("R1", rst_out_n, 1);                       // released after pulse

        // R2: supply drop and recovery.
        cur_req = "R2";
        supply_ok = 0; wait_n(6);
        check("R2", rst_out_n, 0);
        supply_ok = 1; wait_n(RT + 4);
        check("R2", last_lo >= RT, 1);

        // R3: brownout in the middle of the pulse restarts it.
        cur_req = "R3";
        supply_ok = 0; wait_n(4); supply_ok = 1; wait_n(RT / 2);
        supply_ok = 0; wait_n(3); supply_ok = 1;
        wait_n(RT - 2);
        check("R3", rst_out_n, 0);                       // old count would have ended
        wait_n(10);
        check("R3", rst_out_n, 1);

        // R4/R7: constant driven high gives the repeating pattern.
        cur_req = "R4";
        wdog_code = 2'b01;
        wait_n(3 * (WT + RT) + 5);
        check("R4", last_lo, RT);
        check("R7", last_hi, WT);
        wdog_code = 2'b00;
        wait_n(2 * (WT + RT) + 5);
        check("R7", last_lo, RT);

        // R5: toggling faster than the timeout keeps reset released.
        cur_req = "R5";
        wait_n(RT + 2);
        for (int i = 0; i < 12; i++) begin
            wdog_code = wdog_code ^ 2'b01; wait_n(WT / 2);
        end
        check("R5", hi_run > 5 * WT, 1);

        // R6: floating disables the watchdog.
        cur_req = "R6";
        wdog_code = 2'b11; wait_n(4 * WT);
        check("R6", rst_out_n, 1);
        wdog_code = 2'b10; wait_n(WT);
        check("R6", rst_out_n, 1);
        wdog_code = 2'b00; wait_n(WT - 5);               // float->low is no kick
        check("R6", rst_out_n, 1);
        wait_n(10);
        check("R6", rst_out_n, 0);

        // Random mix compared against the model.
        cur_req = "R2";
        void'($urandom(32'h5a5a1234));
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 3);
            if (sel == 0) begin
                cur_req = "R3"; supply_ok = 0;
                wait_n($urandom_range(1, 8)); supply_ok = 1;
            end else begin
                cur_req = (sel == 1) ? "R5" : "R4";
                wdog_code = 2'($urandom_range(0, 3));
            end
            wait_n($urandom_range(1, 70));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule